// File: doc/BRIEF.md
# Status Byte and Service Request Logic

This block holds the eight-bit status byte of an instrument's remote-control port and drives the service-request line toward the bus controller. Each cycle it condenses three event-status registers and the standard event-status register into one summary bit apiece. It also takes the output-queue "not empty" flag as the message-available bit. A writable enable mask selects which status bits may ask for service.

Bit 6 of the byte has two meanings. The master summary (MSS) is a live level: the OR of every enabled status bit. It is seen only through the status query, and neither a serial poll nor a clear-status command removes it. The request flag (SRQ) is sticky. A 0-to-1 change of any enabled bit sets it. A serial poll returns it and clears it in the same step, and a clear-status command also withdraws it. The service-request output follows the flag.

The poll and query strobes each capture their byte into an output register. The byte then holds until the next strobe of the same kind.

Top module: `stb_srq_unit`

## Requirements
- R1: Bit 0, bit 1 and bit 2 are the OR of event registers 0, 1 and 2. Bit 5 is the OR of the standard event register. Bit 4 equals the queue-not-empty flag. Both read bytes carry these values.
- R2: Bits 7 and 3 of both read bytes are always 0, whatever the mask holds.
- R3: Bit 6 of the query byte is MSS, the OR of (status bits 0 to 5) AND the mask. Mask bit 6 has no effect, and mask bits 7 and 3 have no effect.
- R4: When an enabled status bit goes from 0 in one cycle to 1 in the next, SRQ sets at that clock edge, and srv_req is high from then on.
- R5: A 0-to-1 change of a status bit whose mask bit is 0 does not set SRQ.
- R6: A poll_rd pulse captures poll_byte with SRQ in bit 6 and live status in bits 0 to 5, and clears SRQ at the same edge.
- R7: When a new enabled rising edge arrives in the same cycle as a poll or clear-status, SRQ stays set.
- R8: MSS stays 1 across polls and clear-status commands while an enabled status bit is 1, and drops to 0 once none is.
- R9: A clr_stat pulse clears SRQ, so srv_req falls after that edge.
- R10: Reset clears the mask, SRQ, the edge history and both read bytes.
- R11: A write to en_data with en_wr loads the mask at that edge. Enabling a status bit that is already 1 counts as a rising edge one cycle later.
- R12: Each read byte holds its value until its own strobe comes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt0_bits | input | EVT_W | Event-status register 0 contents |
| evt1_bits | input | EVT_W | Event-status register 1 contents |
| evt2_bits | input | EVT_W | Event-status register 2 contents |
| std_evt_bits | input | STD_W | Standard event-status register contents |
| queue_nonempty | input | 1 | Output queue holds a message |
| en_wr | input | 1 | Load the enable mask |
| en_data | input | 8 | New enable mask value |
| poll_rd | input | 1 | Serial-poll read strobe |
| query_rd | input | 1 | Status-byte query strobe |
| clr_stat | input | 1 | Clear-status strobe |
| poll_byte | output | 8 | Byte returned by the last serial poll |
| query_byte | output | 8 | Byte returned by the last query |
| srv_req | output | 1 | Service-request line |

## Verification
The read bytes are due one edge after their strobe, so the bench raises a strobe at a falling edge and samples at the next falling edge. srv_req reacts one edge after the enabled bit changes, and the bench checks it at the first falling edge after that. A mask write takes two edges to show: one to load the mask and one for the edge detector to see the change. For that case the bench checks that srv_req is still low after the first edge and high after the second.

// File: rtl/stb_pkg.sv
package stb_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_EVT  = 3;
    localparam int BIT_SUMM = 6;

    // Status bits that may contribute to the summary (all but bit 6)
    localparam logic [BYTE_W-1:0] SUMM_SRC = 8'b1011_1111;

    typedef struct packed {
        logic spare7;
        logic summ;
        logic std_sum;
        logic msg_avail;
        logic spare3;
        logic ev2_sum;
        logic ev1_sum;
        logic ev0_sum;
    } status_t;

    function automatic status_t build_status(
        input logic [NUM_EVT-1:0] ev_sum,
        input logic               std_sum,
        input logic               msg_avail
    );
        status_t s;
        s           = '0;
        s.ev0_sum   = ev_sum[0];
        s.ev1_sum   = ev_sum[1];
        s.ev2_sum   = ev_sum[2];
        s.std_sum   = std_sum;
        s.msg_avail = msg_avail;
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] with_bit6(input status_t s, input logic b6);
        logic [BYTE_W-1:0] v;
        v           = s;
        v[BIT_SUMM] = b6;
        v[7]        = 1'b0;
        v[3]        = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/stb_summary.sv
module stb_summary
    import stb_pkg::*;
#(
    parameter int EVT_W = 8,
    parameter int STD_W = 8
) (
    input  logic [NUM_EVT-1:0][EVT_W-1:0] evt_regs,
    input  logic [STD_W-1:0]              std_reg,
    input  logic                          msg_avail,
    output status_t                       live
);
    logic [NUM_EVT-1:0] ev_sum;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_sum
        assign ev_sum[g] = |evt_regs[g];
    end

    assign live = build_status(ev_sum, |std_reg, msg_avail);

endmodule

// File: rtl/stb_edge_detect.sv
module stb_edge_detect
    import stb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] masked,
    output logic              rise_any
);
    logic [BYTE_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= masked;
    end

    assign rise_any = |(masked & ~hist_q);

endmodule

// File: rtl/stb_srq_flag.sv
module stb_srq_flag (
    input  logic clk,
    input  logic rst,
    input  logic rise_any,
    input  logic drop_req,
    output logic srq_q
);
    always_ff @(posedge clk) begin
        if (rst)           srq_q <= 1'b0;
        else if (rise_any) srq_q <= 1'b1;
        else if (drop_req) srq_q <= 1'b0;
    end
endmodule

// File: rtl/stb_read_port.sv
module stb_read_port
    import stb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              poll_rd,
    input  logic              query_rd,
    input  status_t           live,
    input  logic              srq,
    input  logic              mss,
    output logic [BYTE_W-1:0] poll_byte,
    output logic [BYTE_W-1:0] query_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            poll_byte  <= '0;
            query_byte <= '0;
        end else begin
            if (poll_rd)  poll_byte  <= with_bit6(live, srq);
            if (query_rd) query_byte <= with_bit6(live, mss);
        end
    end
endmodule

// File: rtl/stb_srq_unit.sv
module stb_srq_unit
    import stb_pkg::*;
#(
    parameter int EVT_W = 8,
    parameter int STD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_W-1:0]  evt0_bits,
    input  logic [EVT_W-1:0]  evt1_bits,
    input  logic [EVT_W-1:0]  evt2_bits,
    input  logic [STD_W-1:0]  std_evt_bits,
    input  logic              queue_nonempty,
    input  logic              en_wr,
    input  logic [7:0]        en_data,
    input  logic              poll_rd,
    input  logic              query_rd,
    input  logic              clr_stat,
    output logic [7:0]        poll_byte,
    output logic [7:0]        query_byte,
    output logic              srv_req
);
    status_t                       live;
    logic [BYTE_W-1:0]             mask_q;
    logic [BYTE_W-1:0]             masked;
    logic                          mss;
    logic                          rise_any;
    logic                          srq_q;
    logic [NUM_EVT-1:0][EVT_W-1:0] evt_regs;

    assign evt_regs = {evt2_bits, evt1_bits, evt0_bits};

    always_ff @(posedge clk) begin
        if (rst)        mask_q <= '0;
        else if (en_wr) mask_q <= en_data;
    end

    stb_summary #(.EVT_W(EVT_W), .STD_W(STD_W)) u_sum (
        .evt_regs  (evt_regs),
        .std_reg   (std_evt_bits),
        .msg_avail (queue_nonempty),
        .live      (live)
    );

    assign masked = live & mask_q & SUMM_SRC;
    assign mss    = |masked;

    stb_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .masked   (masked),
        .rise_any (rise_any)
    );

    stb_srq_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .rise_any (rise_any),
        .drop_req (poll_rd | clr_stat),
        .srq_q    (srq_q)
    );

    stb_read_port u_rd (
        .clk        (clk),
        .rst        (rst),
        .poll_rd    (poll_rd),
        .query_rd   (query_rd),
        .live       (live),
        .srq        (srq_q),
        .mss        (mss),
        .poll_byte  (poll_byte),
        .query_byte (query_byte)
    );

    assign srv_req = srq_q;

endmodule

// File: rtl/stb_srq_unit_chk.sv
module stb_srq_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       poll_rd,
    input logic       query_rd,
    input logic       clr_stat,
    input logic [7:0] poll_byte,
    input logic [7:0] query_byte,
    input logic       srv_req,
    input logic       rise_any,
    input logic       mss
);
    a_r2_spare_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (poll_byte[7] == 1'b0) && (poll_byte[3] == 1'b0) &&
        (query_byte[7] == 1'b0) && (query_byte[3] == 1'b0));

    a_r3_query_carries_mss: assert property (@(posedge clk) disable iff (rst)
        query_rd |=> query_byte[6] == $past(mss));

    a_r4_rise_sets_request: assert property (@(posedge clk) disable iff (rst)
        rise_any |=> srv_req);

    a_r5_no_rise_no_request: assert property (@(posedge clk) disable iff (rst)
        (!srv_req && !rise_any) |=> !srv_req);

    a_r6_poll_reports_flag: assert property (@(posedge clk) disable iff (rst)
        poll_rd |=> poll_byte[6] == $past(srv_req));

    a_r6_poll_clears_flag: assert property (@(posedge clk) disable iff (rst)
        (poll_rd && !rise_any) |=> !srv_req);

    a_r9_clear_drops_flag: assert property (@(posedge clk) disable iff (rst)
        (clr_stat && !rise_any) |=> !srv_req);

    a_r12_poll_byte_holds: assert property (@(posedge clk) disable iff (rst)
        !poll_rd |=> $stable(poll_byte));

    a_r12_query_byte_holds: assert property (@(posedge clk) disable iff (rst)
        !query_rd |=> $stable(query_byte));
endmodule

bind stb_srq_unit stb_srq_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .poll_rd    (poll_rd),
    .query_rd   (query_rd),
    .clr_stat   (clr_stat),
    .poll_byte  (poll_byte),
    .query_byte (query_byte),
    .srv_req    (srv_req),
    .rise_any   (rise_any),
    .mss        (mss)
);

// File: tb/stb_srq_unit_test.sv
`timescale 1ns/1ps
module stb_srq_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] evt0_bits = '0, evt1_bits = '0, evt2_bits = '0, std_evt_bits = '0;
    logic       queue_nonempty = 1'b0;
    logic       en_wr = 1'b0;
    logic [7:0] en_data = '0;
    logic       poll_rd = 1'b0, query_rd = 1'b0, clr_stat = 1'b0;
    logic [7:0] poll_byte, query_byte;
    logic       srv_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    stb_srq_unit uut (
        .clk(clk), .rst(rst),
        .evt0_bits(evt0_bits), .evt1_bits(evt1_bits), .evt2_bits(evt2_bits),
        .std_evt_bits(std_evt_bits), .queue_nonempty(queue_nonempty),
        .en_wr(en_wr), .en_data(en_data),
        .poll_rd(poll_rd), .query_rd(query_rd), .clr_stat(clr_stat),
        .poll_byte(poll_byte), .query_byte(query_byte), .srv_req(srv_req)
    );

    typedef struct packed {
        logic [7:0] e0, e1, e2, sd;
        logic       mav;
        logic [7:0] msk;
        logic [7:0] exp_q;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00},
        '{8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h01},
        '{8'h00, 8'h80, 8'h10, 8'h00, 1'b0, 8'h00, 8'h06},
        '{8'h00, 8'h00, 8'h00, 8'h04, 1'b1, 8'h00, 8'h30},
        '{8'h02, 8'h00, 8'h00, 8'h00, 1'b0, 8'h01, 8'h41},
        '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h40, 8'h10},
        '{8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'hFF, 8'h00},
        '{8'h00, 8'h00, 8'h01, 8'h01, 1'b0, 8'h20, 8'h64},
        '{8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h88, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_mask(input logic [7:0] m);
        en_wr = 1'b1; en_data = m; tick(); en_wr = 1'b0;
    endtask

    task automatic pulse_query();
        query_rd = 1'b1; tick(); query_rd = 1'b0;
    endtask

    task automatic pulse_poll();
        poll_rd = 1'b1; tick(); poll_rd = 1'b0;
    endtask

    task automatic pulse_clear();
        clr_stat = 1'b1; tick(); clr_stat = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R10: reset state
        check("R10 poll_byte", poll_byte, 8'h00);
        check("R10 query_byte", query_byte, 8'h00);
        check("R10 srv_req", {7'd0, srv_req}, 8'h00);
        rst = 1'b0;
        tick();

        // R1 R2 R3: vector table walk
        for (int i = 0; i < NV; i++) begin
            evt0_bits = VECS[i].e0; evt1_bits = VECS[i].e1;
            evt2_bits = VECS[i].e2; std_evt_bits = VECS[i].sd;
            queue_nonempty = VECS[i].mav;
            write_mask(VECS[i].msk);
            pulse_query();
            check("R1/R2/R3 query table", query_byte, VECS[i].exp_q);
        end

        // quiet state, mask bit 0 only
        evt0_bits = '0; evt1_bits = '0; evt2_bits = '0; std_evt_bits = '0;
        queue_nonempty = 1'b0;
        write_mask(8'h01);
        tick();
        pulse_clear();
        check("R9 quiet start", {7'd0, srv_req}, 8'h00);

        // R4: enabled rise
        evt0_bits = 8'h04; tick();
        check("R4 srv_req after rise", {7'd0, srv_req}, 8'h01);

        // R6: poll returns and clears
        pulse_poll();
        check("R6 poll_byte", poll_byte, 8'h41);
        check("R6 srv_req cleared", {7'd0, srv_req}, 8'h00);

        // R8: MSS survives poll and clear
        pulse_query();
        check("R8 MSS after poll", query_byte, 8'h41);
        pulse_clear();
        pulse_query();
        check("R8 MSS after clear", query_byte, 8'h41);

        // R12: poll byte holds while status changes
        std_evt_bits = 8'h01; tick();
        check("R12 poll_byte held", poll_byte, 8'h41);

        // R5: masked bit rising does not request
        check("R5 masked rise", {7'd0, srv_req}, 8'h00);

        evt0_bits = 8'h00; std_evt_bits = 8'h00; tick();
        pulse_query();
        check("R8 MSS gone", query_byte, 8'h00);

        // R9: clear drops request
        evt0_bits = 8'h01; tick();
        check("R4 second rise", {7'd0, srv_req}, 8'h01);
        pulse_clear();
        check("R9 clear drops", {7'd0, srv_req}, 8'h00);

        // R7: rise together with poll keeps request
        evt0_bits = 8'h00; tick();
        evt0_bits = 8'h01; pulse_poll();
        check("R7 srq kept", {7'd0, srv_req}, 8'h01);
        check("R7 poll saw old flag", poll_byte, 8'h01);
        evt0_bits = 8'h00; tick();
        evt0_bits = 8'h01; clr_stat = 1'b1; tick(); clr_stat = 1'b0;
        check("R7 srq kept on clear", {7'd0, srv_req}, 8'h01);

        // R11: enabling an already-high bit
        pulse_poll();
        queue_nonempty = 1'b1; tick();
        check("R11 before write", {7'd0, srv_req}, 8'h00);
        write_mask(8'h11);
        check("R11 one edge", {7'd0, srv_req}, 8'h00);
        tick();
        check("R11 two edges", {7'd0, srv_req}, 8'h01);

        // R10: reset mid-run
        rst = 1'b1; tick(); rst = 1'b0;
        check("R10 srv_req", {7'd0, srv_req}, 8'h00);
        check("R10 poll_byte", poll_byte, 8'h00);
        pulse_query();
        check("R10 mask cleared", query_byte, 8'h11);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule